// File: doc/BRIEF.md
# Shared Split-Transaction Request Gate

This block decides when a transmit requester and a receive requester may each issue a read request into a shared pool of outstanding split transactions on a bus interface. It keeps a count of the transactions in flight. The count rises by one on every grant and falls by one on every completion strobe. A grant is given only when the count is below two limits.

The first limit is the total pool size, decoded from a 3-bit code. The steps of this code are not evenly spaced. The second limit is a 5-bit shared-split value that applies to transmit requests only. When the shared-split value is zero, transmit is not held to any separate ceiling and both requesters draw on the whole pool.

Each requester uses a plain request/grant pair. A grant is a combinational answer to the request in the same cycle, and the request counts as issued on the clock edge where its grant is high. A requester that sees no grant simply holds its request. No data passes through this block; bus signalling, tags and returned data are handled elsewhere.

Top module: `split_req_gate`

## Requirements
- R1: After reset, the outstanding count is 0 and the error flag is 0.
- R2: The total limit is taken from the maximum-outstanding code as follows: 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4, 4 gives 8, 5 gives 12, 6 gives 16 and 7 gives 32.
- R3: A receive request is eligible whenever the outstanding count is below the decoded total limit.
- R4: When the shared-split value is nonzero, a transmit request is not granted once the outstanding count is at or above that value, even if the total limit has not been reached.
- R5: When the shared-split value is 0, a transmit request is eligible whenever the count is below the decoded total limit.
- R6: At most one grant is high in any cycle, and a grant is never high without its request. When both requesters are eligible, the one that was not granted most recently wins. After reset, receive has priority.
- R7: The count increments on a grant and decrements on a completion strobe. A grant and a completion in the same cycle leave the count unchanged.
- R8: A completion strobe that arrives while the count is 0 does not decrement the count, and it sets an error flag. Only reset clears this flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Transmit requester wants to issue a read |
| tx_gnt | output | 1 | Transmit request issued this cycle |
| rx_req | input | 1 | Receive requester wants to issue a read |
| rx_gnt | output | 1 | Receive request issued this cycle |
| cpl_stb | input | 1 | One outstanding split transaction retired |
| max_code | input | 3 | Total-outstanding limit code |
| share_lim | input | 5 | Transmit ceiling; 0 means no separate ceiling |
| out_cnt | output | 6 | Current outstanding count |
| cpl_err | output | 1 | Sticky flag for a completion that arrived with nothing outstanding |

## Verification
The bench builds the block with its default 3-bit code and 5-bit shared-split width. It sweeps all 256 combinations of code and shared-split value. For each combination it fills the pool with transmit requests and then with receive requests. It compares where each requester stalls against values it computes arithmetically from the decode table and the ceiling. It then drains the pool back to zero. This covers every decode step, the case where the shared-split value is above the total limit, and the case where it is zero. Separate sequences check the round-robin order, a grant and a completion in the same cycle, and a completion that arrives while the count is already zero.

// File: rtl/split_gate_pkg.sv
package split_gate_pkg;
  localparam int CODE_W   = 3;
  localparam int POOL_MAX = 32;
  localparam int CNT_W    = $clog2(POOL_MAX + 1);

  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/split_limit_decode.sv
module split_limit_decode
  import split_gate_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output cnt_t              limit
);
  always_comb begin
    unique case (code)
      3'd0:    limit = cnt_t'(1);
      3'd1:    limit = cnt_t'(2);
      3'd2:    limit = cnt_t'(3);
      3'd3:    limit = cnt_t'(4);
      3'd4:    limit = cnt_t'(8);
      3'd5:    limit = cnt_t'(12);
      3'd6:    limit = cnt_t'(16);
      default: limit = cnt_t'(POOL_MAX);
    endcase
  end
endmodule

// File: rtl/split_rr_arb.sv
module split_rr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic rx_req,
  input  logic tx_ok,
  input  logic rx_ok,
  output logic tx_gnt,
  output logic rx_gnt
);
  logic tx_turn;
  logic tx_elig, rx_elig;

  assign tx_elig = tx_req && tx_ok;
  assign rx_elig = rx_req && rx_ok;

  always_comb begin
    tx_gnt = 1'b0;
    rx_gnt = 1'b0;
    if (tx_elig && rx_elig) begin
      tx_gnt = tx_turn;
      rx_gnt = !tx_turn;
    end else begin
      tx_gnt = tx_elig;
      rx_gnt = rx_elig;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tx_turn <= 1'b0;
    else if (tx_gnt) tx_turn <= 1'b0;
    else if (rx_gnt) tx_turn <= 1'b1;
  end

  // R6: the two grants are never high together
  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_gnt, rx_gnt}));
  // R6: the loser of a contested cycle wins when both contend next
  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt && rx_elig) |=> (tx_elig && rx_elig) |-> rx_gnt);
endmodule

// File: rtl/split_out_ctr.sv
module split_out_ctr
  import split_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic cpl_stb,
  output cnt_t cnt,
  output logic err
);
  logic retire;
  assign retire = cpl_stb && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      if (issue && !retire)      cnt <= cnt + cnt_t'(1);
      else if (retire && !issue) cnt <= cnt - cnt_t'(1);
      if (cpl_stb && cnt == '0)  err <= 1'b1;
    end
  end

  // R7: an idle cycle leaves the count unchanged
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !cpl_stb) |=> $stable(cnt));
  // R8: a completion at zero with no issue keeps the count at zero
  assert_empty_cpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_stb && cnt == '0 && !issue) |=> (cnt == '0) && err);
  // R8: the error flag stays set until reset
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/split_req_gate.sv
module split_req_gate
  import split_gate_pkg::*;
#(
  parameter int SHARE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_req,
  output logic               tx_gnt,
  input  logic               rx_req,
  output logic               rx_gnt,
  input  logic               cpl_stb,
  input  logic [CODE_W-1:0]  max_code,
  input  logic [SHARE_W-1:0] share_lim,
  output logic [CNT_W-1:0]   out_cnt,
  output logic               cpl_err
);
  localparam int CMP_W = (SHARE_W > CNT_W) ? SHARE_W : CNT_W;

  cnt_t total_lim;
  logic below_total, below_share, tx_ok;

  split_limit_decode u_dec (.code(max_code), .limit(total_lim));

  assign below_total = out_cnt < total_lim;
  assign below_share = CMP_W'(out_cnt) < CMP_W'(share_lim);
  assign tx_ok       = below_total && ((share_lim == '0) || below_share);

  split_rr_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .tx_req(tx_req), .rx_req(rx_req),
    .tx_ok(tx_ok), .rx_ok(below_total),
    .tx_gnt(tx_gnt), .rx_gnt(rx_gnt)
  );

  split_out_ctr u_ctr (
    .clk(clk), .rst_n(rst_n),
    .issue(tx_gnt || rx_gnt), .cpl_stb(cpl_stb),
    .cnt(out_cnt), .err(cpl_err)
  );

  // R3: no grant is given with the pool full
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt || rx_gnt) |-> (out_cnt < total_lim));
  // R4: transmit never passes a nonzero shared ceiling
  assert_tx_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt && share_lim != '0) |-> (CMP_W'(out_cnt) < CMP_W'(share_lim)));
  // R6: no grant without its request
  assert_gnt_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_req -> !tx_gnt) && (!rx_req -> !rx_gnt));
endmodule

// File: tb/tb_split_req_gate.sv
`timescale 1ns/1ps
module tb_split_req_gate;
  logic clk = 0, rst_n = 0;
  logic tx_req = 0, rx_req = 0, cpl_stb = 0;
  logic [2:0] max_code = 0;
  logic [4:0] share_lim = 0;
  logic tx_gnt, rx_gnt, cpl_err;
  logic [5:0] out_cnt;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  split_req_gate dut (.*);

  function automatic int exp_total(int c);
    if (c < 4) return c + 1;
    if (c == 7) return 32;
    return (c - 2) * 4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    tx_req = 0; rx_req = 0; cpl_stb = 0; rst_n = 0;
    cyc(); rst_n = 1; #1;
  endtask

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int txn, rxn, et, es;
    cyc();
    do_reset();
    chk("R1 count", out_cnt, 0);
    chk("R1 err", cpl_err, 0);

    // Sweep every code and shared-split value
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 32; s++) begin
        max_code = 3'(c); share_lim = 5'(s);
        do_reset();
        et = exp_total(c);
        es = (s == 0) ? et : ((s < et) ? s : et);
        txn = 0; tx_req = 1; #1;
        for (int k = 0; k < 40; k++) begin
          if (tx_gnt) txn++;
          cyc();
        end
        tx_req = 0; #1;
        chk((s == 0) ? "R5 tx fill" : "R4 tx fill", txn, es);
        rxn = 0; rx_req = 1; #1;
        for (int k = 0; k < 40; k++) begin
          if (rx_gnt) rxn++;
          cyc();
        end
        rx_req = 0; #1;
        chk("R3 rx fill", rxn, et - es);
        chk("R2 full count", out_cnt, et);
        cpl_stb = 1;
        for (int k = 0; k < et; k++) cyc();
        cpl_stb = 0; #1;
        chk("R7 drained", out_cnt, 0);
        chk("R8 no err", cpl_err, 0);
      end
    end

    // Round-robin with both eligible
    max_code = 3'd7; share_lim = 5'd0;
    do_reset();
    tx_req = 1; rx_req = 1; #1;
    for (int k = 0; k < 6; k++) begin
      chk("R6 rr rx", rx_gnt, (k % 2 == 0) ? 1 : 0);
      chk("R6 rr tx", tx_gnt, (k % 2 == 1) ? 1 : 0);
      cyc();
    end
    tx_req = 0; rx_req = 0; #1;
    chk("R7 six issued", out_cnt, 6);

    // Grant and completion together
    rx_req = 1; cpl_stb = 1; #1;
    chk("R6 rx alone", rx_gnt, 1);
    cyc();
    rx_req = 0; cpl_stb = 0; #1;
    chk("R7 simultaneous", out_cnt, 6);

    // Completion at zero
    do_reset();
    cpl_stb = 1; cyc(); cpl_stb = 0; #1;
    chk("R8 count held", out_cnt, 0);
    chk("R8 err set", cpl_err, 1);
    rx_req = 1; cyc(); rx_req = 0; cpl_stb = 1; cyc(); cpl_stb = 0; #1;
    chk("R8 err sticky", cpl_err, 1);
    chk("R7 back to zero", out_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule